// File: doc/BRIEF.md
# Segment and Page Descriptor Cache

This block sits inside the translation unit of a segmented, paged virtual-memory system. It keeps recently used descriptors so that a translation can skip the walk through the in-memory tables. There are two independent two-way set-associative caches. One holds segment descriptors (two 32-bit words each) and is keyed by the section number and the segment index of the virtual address. The other holds page descriptors (one 32-bit word each) and is keyed by the section number, the segment index and the page index.

A lookup is answered in the same cycle from registered arrays. Each cache gives a hit or a miss, and on a hit it also gives the descriptor. After a miss, the external table walker writes what it fetched through the fill port. The walker supplies the segment descriptor with every fill, and can add a page descriptor. If that segment descriptor carries the no-cache flag, neither cache stores anything, and the walker uses its result uncached.

The cache never watches memory writes. Software that edits the tables in memory goes on receiving the old cached copies until it issues a flush, and the flush empties both caches at once.

Top module: `mmu_desc_cache`

## Requirements
- R1: With `lk_en` high, each cache asserts its hit output and returns the stored descriptor in the same cycle when its key is present. It asserts miss otherwise. With `lk_en` low, hit and miss are both low. The data outputs are zero whenever the matching hit is low.
- R2: A segment entry is identified by the complete pair {section, segment index}. Its set is the segment index bits [2:0], taken as an index and never shifted. A lookup that differs only in the section or in the upper segment bits misses.
- R3: A page entry is identified by the complete triple {section, segment index, page index}. Its set is the page index bits [3:0]. A lookup with the same page index but a different segment or section misses.
- R4: Each set holds two entries. When a fill brings a new key into a full set, the entry that was least recently filled or hit is evicted. A hit in the same cycle as a fill to that set does not change the choice of victim.
- R5: A fill whose key is already present overwrites that entry in place. A key never occupies both ways, and a later lookup returns the newest data.
- R6: When bit 2 of the low segment-descriptor word in a fill is 1 (no-cache), both caches ignore that fill. When the bit is 0, the fill is stored.
- R7: A flush invalidates every entry of both caches in one cycle. A lookup in the next cycle misses. A fill in the same cycle as a flush is dropped.
- R8: An entry keeps returning the same descriptor, unchanged, until it is flushed or evicted. No memory activity alters it.
- R9: After reset, every lookup misses until a fill occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate both caches |
| lk_en | input | 1 | Lookup request |
| lk_sec | input | SEC_W | Section number of the lookup |
| lk_seg | input | SEG_W | Segment index of the lookup |
| lk_page | input | PAGE_W | Page index of the lookup |
| sd_hit | output | 1 | Segment descriptor found |
| sd_miss | output | 1 | Segment descriptor absent |
| sd_lo | output | 32 | Segment descriptor low word |
| sd_hi | output | 32 | Segment descriptor high word |
| pd_hit | output | 1 | Page descriptor found |
| pd_miss | output | 1 | Page descriptor absent |
| pd_word | output | 32 | Page descriptor |
| fill_en | input | 1 | Store the segment descriptor |
| fill_pd_en | input | 1 | Store the page descriptor |
| fill_sec | input | SEC_W | Section number of the fill |
| fill_seg | input | SEG_W | Segment index of the fill |
| fill_page | input | PAGE_W | Page index of the fill |
| fill_sd_lo | input | 32 | Fetched segment descriptor low word (bit 2 = no-cache) |
| fill_sd_hi | input | 32 | Fetched segment descriptor high word |
| fill_pd | input | 32 | Fetched page descriptor |

## Verification
Two pairs of functions can land in the same cycle. A flush can arrive together with a fill, and a lookup hit can arrive together with a fill to the same set. The bench provokes both pairs on purpose: first in directed steps, then in a long random run over a small key space where they collide often. A behavioural model then judges each outcome. In that model the flush discards the fill, and the victim for the fill is chosen from the recency order as it stood before the hit.

// File: rtl/mmu_dc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the descriptor cache.
// Assumes descriptor words are 32 bits wide.
package mmu_dc_pkg;
    localparam int DESC_W = 32;   // width of one descriptor word
    localparam int NC_BIT = 2;    // no-cache flag position in the low segment word (1 = do not cache)
endpackage

// File: rtl/dc_victim_pick.sv
`timescale 1ns/1ps
// Chooses the way that a fill writes in a two-way set.
// Order of preference: the way already holding the key, then an invalid way, then the LRU way.
// Assumes `same` is never 2'b11, because keys are unique within a set.
module dc_victim_pick (
    input  logic [1:0] vld,
    input  logic [1:0] same,
    input  logic       lru,
    output logic       way
);
    // Priority choice of the target way.
    always_comb begin
        if (same[0])      way = 1'b0;
        else if (same[1]) way = 1'b1;
        else if (!vld[0]) way = 1'b0;
        else if (!vld[1]) way = 1'b1;
        else              way = lru;
    end
endmodule

// File: rtl/dc_assoc2.sv
`timescale 1ns/1ps
// Two-way set-associative store keyed by a full index.
// The low SET_W key bits choose the set. The remaining bits form the whole tag.
// The lookup is combinational. A fill and the LRU/valid state update on the clock edge, and flush overrides a fill.
// Assumes KEY_W > SET_W.
module dc_assoc2 #(
    parameter int KEY_W  = 15,
    parameter int SET_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_en,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              hit,
    output logic              miss,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = KEY_W - SET_W;

    logic [1:0]        vld_q [SETS];
    logic [TAG_W-1:0]  tag_q [SETS][2];
    logic [DATA_W-1:0] dat_q [SETS][2];
    logic [SETS-1:0]   lru_q;          // way to evict next, one bit per set

    logic [SET_W-1:0] l_set, w_set;
    logic [TAG_W-1:0] l_tag, w_tag;
    logic [1:0]       l_match, w_same;
    logic             hit_way, w_way;

    assign l_set = lk_key[SET_W-1:0];
    assign l_tag = lk_key[KEY_W-1:SET_W];
    assign w_set = wr_key[SET_W-1:0];
    assign w_tag = wr_key[KEY_W-1:SET_W];

    // Compare the full tag in both ways for the lookup and for the fill.
    always_comb begin
        for (int w = 0; w < 2; w++) begin
            l_match[w] = vld_q[l_set][w] && (tag_q[l_set][w] == l_tag);
            w_same[w]  = vld_q[w_set][w] && (tag_q[w_set][w] == w_tag);
        end
    end

    assign hit_way = l_match[1];
    assign hit     = lk_en && (l_match != 2'b00);
    assign miss    = lk_en && (l_match == 2'b00);
    assign rd_data = hit ? dat_q[l_set][hit_way] : '0;

    dc_victim_pick u_pick (
        .vld  (vld_q[w_set]),
        .same (w_same),
        .lru  (lru_q[w_set]),
        .way  (w_way)
    );

    // Valid and LRU state: reset, flush, hit touch, fill (a fill wins the LRU bit).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= 2'b00;
            lru_q <= '0;
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= 2'b00;
        end else begin
            if (hit) lru_q[l_set] <= ~hit_way;
            if (wr_en) begin
                vld_q[w_set][w_way] <= 1'b1;
                lru_q[w_set]        <= ~w_way;
            end
        end
    end

    // Tag and data storage, written only by a fill that survives.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[w_set][w_way] <= w_tag;
            dat_q[w_set][w_way] <= wr_data;
        end
    end

    // R1: a lookup reports exactly one of hit or miss, and nothing without a request.
    p_hit_xor_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || miss) == lk_en && !(hit && miss));

    // R7: after a flush the next lookup cannot hit.
    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

    // R8: a hit with no flush or fill repeats on the same key one cycle later.
    p_retain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !flush && !wr_en) |=>
        (!(lk_en && lk_key == $past(lk_key)) || (hit && rd_data == $past(rd_data))));

    // R5: no set ever holds the same tag in both ways.
    for (genvar s = 0; s < SETS; s++) begin : g_dup
        p_no_dup_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(vld_q[s] == 2'b11 && tag_q[s][0] == tag_q[s][1]));
    end
endmodule

// File: rtl/mmu_desc_cache.sv
`timescale 1ns/1ps
// Segment and page descriptor cache for a segmented, paged translation unit.
// The segment cache is keyed by {section, segment}, the page cache by {section, segment, page}.
// A fill whose segment descriptor has the no-cache flag set is dropped by both caches.
// Assumes the walker presents the segment descriptor with every fill.
module mmu_desc_cache
    import mmu_dc_pkg::*;
#(
    parameter int SEC_W     = 2,
    parameter int SEG_W     = 13,
    parameter int PAGE_W    = 6,
    parameter int SD_SET_W  = 3,
    parameter int PD_SET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_en,
    input  logic [SEC_W-1:0]  lk_sec,
    input  logic [SEG_W-1:0]  lk_seg,
    input  logic [PAGE_W-1:0] lk_page,
    output logic              sd_hit,
    output logic              sd_miss,
    output logic [DESC_W-1:0] sd_lo,
    output logic [DESC_W-1:0] sd_hi,
    output logic              pd_hit,
    output logic              pd_miss,
    output logic [DESC_W-1:0] pd_word,
    input  logic              fill_en,
    input  logic              fill_pd_en,
    input  logic [SEC_W-1:0]  fill_sec,
    input  logic [SEG_W-1:0]  fill_seg,
    input  logic [PAGE_W-1:0] fill_page,
    input  logic [DESC_W-1:0] fill_sd_lo,
    input  logic [DESC_W-1:0] fill_sd_hi,
    input  logic [DESC_W-1:0] fill_pd
);
    localparam int SD_KEY_W = SEC_W + SEG_W;
    localparam int PD_KEY_W = SEC_W + SEG_W + PAGE_W;

    logic              cacheable;
    logic [2*DESC_W-1:0] sd_rd;

    // The flag is active-low for caching: 1 forbids storing the descriptor and its pages.
    assign cacheable = !fill_sd_lo[NC_BIT];

    dc_assoc2 #(.KEY_W(SD_KEY_W), .SET_W(SD_SET_W), .DATA_W(2*DESC_W)) u_sd (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .lk_en   (lk_en),
        .lk_key  ({lk_sec, lk_seg}),
        .hit     (sd_hit),
        .miss    (sd_miss),
        .rd_data (sd_rd),
        .wr_en   (fill_en && cacheable),
        .wr_key  ({fill_sec, fill_seg}),
        .wr_data ({fill_sd_hi, fill_sd_lo})
    );

    assign sd_lo = sd_rd[DESC_W-1:0];
    assign sd_hi = sd_rd[2*DESC_W-1:DESC_W];

    dc_assoc2 #(.KEY_W(PD_KEY_W), .SET_W(PD_SET_W), .DATA_W(DESC_W)) u_pd (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .lk_en   (lk_en),
        .lk_key  ({lk_sec, lk_seg, lk_page}),
        .hit     (pd_hit),
        .miss    (pd_miss),
        .rd_data (pd_word),
        .wr_en   (fill_pd_en && cacheable),
        .wr_key  ({fill_sec, fill_seg, fill_page}),
        .wr_data (fill_pd)
    );

    // R6: a no-cache fill never makes a hit appear on the same key next cycle.
    p_nocache_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !cacheable && !sd_hit && lk_en && lk_sec == fill_sec && lk_seg == fill_seg && !flush)
        |=> !(lk_en && lk_sec == $past(lk_sec) && lk_seg == $past(lk_seg) && sd_hit));
endmodule

// File: tb/tb_mmu_desc_cache.sv
`timescale 1ns/1ps
module tb_mmu_desc_cache;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0, lk_en = 0, fill_en = 0, fill_pd_en = 0;
    logic [1:0]  lk_sec = 0, fill_sec = 0;
    logic [12:0] lk_seg = 0, fill_seg = 0;
    logic [5:0]  lk_page = 0, fill_page = 0;
    logic [31:0] fill_sd_lo = 0, fill_sd_hi = 0, fill_pd = 0;
    logic        sd_hit, sd_miss, pd_hit, pd_miss;
    logic [31:0] sd_lo, sd_hi, pd_word;

    always #4 clk = ~clk;   // 125 MHz

    mmu_desc_cache dut (.*);

    int tests = 0, fails = 0, now_t = 0;
    string req = "R9";
    logic [63:0] mdat [int];   // key -> descriptor
    int          mage [int];   // key -> last use time

    function automatic int sd_key(int sec, int seg);
        return (sec << 13) | seg;
    endfunction
    function automatic int pd_key(int sec, int seg, int pg);
        return (1 << 28) | (sec << 19) | (seg << 6) | pg;
    endfunction
    // Set identity: segment set = seg[2:0], page set = page[3:0], kept apart per cache.
    function automatic int set_of(int key);
        if (key >> 28) return 256 | (key & 15);
        return key & 7;
    endfunction

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_fill(int key, logic [63:0] d);
        int cnt = 0, old = -1, oldt = 0;
        if (mdat.exists(key)) begin mdat[key] = d; mage[key] = now_t; return; end
        foreach (mdat[k]) if (set_of(k) == set_of(key)) begin
            cnt++;
            if (old < 0 || mage[k] < oldt) begin old = k; oldt = mage[k]; end
        end
        if (cnt >= 2) begin mdat.delete(old); mage.delete(old); end
        mdat[key] = d; mage[key] = now_t;
    endtask

    // Compare this cycle's outputs to the model, then advance the model over the clock edge.
    task automatic tick();
        int ks, kp, fs, fp;
        logic ok;
        #1;
        ks = sd_key(lk_sec, lk_seg);
        kp = pd_key(lk_sec, lk_seg, lk_page);
        chk("sd_hit",  sd_hit,  lk_en && mdat.exists(ks));
        chk("sd_miss", sd_miss, lk_en && !mdat.exists(ks));
        chk("sd_data", {sd_hi, sd_lo}, (lk_en && mdat.exists(ks)) ? mdat[ks] : 64'd0);
        chk("pd_hit",  pd_hit,  lk_en && mdat.exists(kp));
        chk("pd_miss", pd_miss, lk_en && !mdat.exists(kp));
        chk("pd_data", pd_word, (lk_en && mdat.exists(kp)) ? mdat[kp] : 64'd0);
        @(posedge clk);
        now_t++;
        fs = sd_key(fill_sec, fill_seg);
        fp = pd_key(fill_sec, fill_seg, fill_page);
        ok = !fill_sd_lo[2];
        if (flush) begin
            mdat.delete(); mage.delete();
        end else begin
            if (lk_en && mdat.exists(ks) && !(fill_en && ok && set_of(fs) == set_of(ks))) mage[ks] = now_t;
            if (lk_en && mdat.exists(kp) && !(fill_pd_en && ok && set_of(fp) == set_of(kp))) mage[kp] = now_t;
            if (fill_en && ok) model_fill(fs, {fill_sd_hi, fill_sd_lo});
            if (fill_pd_en && ok) model_fill(fp, {32'd0, fill_pd});
        end
        @(negedge clk);
    endtask

    task automatic idle();
        flush = 0; lk_en = 0; fill_en = 0; fill_pd_en = 0;
    endtask
    task automatic look(int sec, int seg, int pg);
        idle(); lk_en = 1; lk_sec = sec[1:0]; lk_seg = seg[12:0]; lk_page = pg[5:0]; tick();
    endtask
    task automatic fill(int sec, int seg, int pg, logic [31:0] lo, logic [31:0] hi, logic [31:0] pd);
        idle(); fill_en = 1; fill_pd_en = 1; fill_sec = sec[1:0]; fill_seg = seg[12:0];
        fill_page = pg[5:0]; fill_sd_lo = lo; fill_sd_hi = hi; fill_pd = pd; tick();
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        req = "R9"; look(0, 5, 3); look(3, 100, 63);
        req = "R1"; fill(0, 5, 3, 32'h1000_0000, 32'hAAAA_0001, 32'h5000_0001);
        look(0, 5, 3); idle(); tick();
        req = "R2"; look(1, 5, 3); look(0, 13, 3);
        req = "R3"; look(0, 6, 3); look(2, 5, 3); look(0, 5, 19);
        req = "R4"; fill(0, 9, 3, 32'h11, 32'h12, 32'h13);     // segment set 1
        fill(0, 17, 3, 32'h21, 32'h22, 32'h23);
        look(0, 9, 3);
        fill(0, 25, 3, 32'h31, 32'h32, 32'h33);                 // evicts segment 17
        look(0, 17, 3); look(0, 9, 3); look(0, 25, 3);
        // R4: hit and fill to the same set in one cycle
        idle(); lk_en = 1; lk_sec = 0; lk_seg = 9; lk_page = 3;
        fill_en = 1; fill_sec = 0; fill_seg = 33; fill_page = 40; fill_sd_lo = 32'h41; fill_sd_hi = 32'h42; tick();
        look(0, 9, 3); look(0, 25, 3); look(0, 33, 40);
        req = "R5"; fill(1, 2, 7, 32'hB1, 32'hB2, 32'hB3); fill(1, 2, 7, 32'hC1, 32'hC2, 32'hC3);
        look(1, 2, 7); fill(1, 10, 7, 32'hD1, 32'hD2, 32'hD3); look(1, 2, 7); look(1, 10, 7);
        req = "R6"; fill(2, 4, 1, 32'h0000_0004, 32'hE2, 32'hE3); look(2, 4, 1);
        fill(2, 4, 1, 32'h0000_0000, 32'hE2, 32'hE3); look(2, 4, 1);
        req = "R8"; fill(3, 6, 2, 32'hF1, 32'hF2, 32'hF3);
        for (int i = 0; i < 6; i++) fill(0, 64 + i * 8 + 1, 5, i, i, i);
        look(3, 6, 2);
        req = "R7"; idle(); flush = 1; tick(); look(3, 6, 2); look(1, 2, 7);
        fill(0, 5, 3, 32'h10, 32'h20, 32'h30);
        idle(); flush = 1; fill_en = 1; fill_pd_en = 1; fill_seg = 7; fill_page = 7; fill_sd_lo = 0; tick();
        look(0, 7, 7); look(0, 5, 3);
        // R4 R5 R7: random run in a small key space to force collisions
        req = "R4";
        for (int i = 0; i < 3000; i++) begin
            idle();
            lk_en = ($urandom % 4) != 0;
            lk_sec = $urandom % 2; lk_seg = $urandom % 24; lk_page = $urandom % 20;
            fill_en = ($urandom % 3) == 0; fill_pd_en = ($urandom % 3) == 0;
            fill_sec = $urandom % 2; fill_seg = $urandom % 24; fill_page = $urandom % 20;
            fill_sd_lo = $urandom & 32'hFFFF_FFF7; fill_sd_hi = $urandom; fill_pd = $urandom;
            flush = ($urandom % 97) == 0;
            tick();
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule